// File: doc/BRIEF.md
# SIMD Lane Multiply-Accumulate Unit

This block is an integer SIMD datapath. It splits two operand vectors into lanes and multiplies each pair of matching lanes. It then does one of three things with the products: writes them out directly, adds them to the matching lanes of an accumulator vector, or subtracts them from those lanes. Lanes are 8, 16 or 32 bits wide. Vectors are 64 or 128 bits wide, and every lane is computed on its own, with no carry or borrow crossing a lane boundary.

A widening mode takes the low 64 bits of both operands and produces a 128-bit result whose lanes are twice the source lane width. Source lanes are sign-extended or zero-extended, as selected. A carry-less (GF(2)) lane type is available on 8-bit lanes, for plain multiply only, in both same-width and widening form.

The result is registered with one cycle of latency behind a valid pulse. A request that breaks the encoding rules raises an illegal flag and leaves the stored result as it was.

Top module: `simd_mac_unit`

## Requirements
- R1: With `op_sel`=0 (multiply), each result lane is the low lane-width bits of the product of the matching operand lanes.
- R2: With `op_sel`=1 (accumulate), each result lane is the accumulator lane plus the product, taken modulo 2^lane-width.
- R3: With `op_sel`=2 (subtract), each result lane is the accumulator lane minus the product, taken modulo 2^lane-width.
- R4: `lane_sel` picks the source lane width: 0 selects 8 bits, 1 selects 16 bits, 2 selects 32 bits.
- R5: With `quad_en`=0 and `long_en`=0, only bits 63:0 of the operands and accumulator are used, and result bits 127:64 are zero. With `quad_en`=1, all 128 bits are used.
- R6: With `long_en`=1, lanes of `src_a[63:0]` and `src_b[63:0]` produce 128-bit results in lanes of twice the source width, and the accumulator lanes are also twice the source width. `elem_kind`=1 sign-extends the source lanes and `elem_kind`=0 zero-extends them.
- R7: `elem_kind`=2 with 8-bit lanes selects a carry-less product. Same-width mode keeps its low 8 bits, and widening mode gives the full 16-bit product.
- R8: A request is illegal when any of the following holds: `op_sel`=3; `lane_sel`=3; `elem_kind`=3; `elem_kind`=2 together with `op_sel`≠0 or `lane_sel`≠0; or `long_en`=1 together with `quad_en`=1. An illegal request sets `illegal` with its `out_valid`, and the result keeps its previous value.
- R9: `out_valid`, `illegal` and `result` update one cycle after an `in_valid` request. A synchronous active-high reset clears all three.
- R10: A result lane depends only on the same lane of the operands and the accumulator. Overflow in one lane leaves its neighbours untouched.
- R11: In a cycle without `in_valid`, `out_valid` goes low and `result` and `illegal` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | 0 multiply, 1 accumulate, 2 subtract |
| lane_sel | input | 2 | Source lane width: 0 = 8, 1 = 16, 2 = 32 bits |
| elem_kind | input | 2 | 0 unsigned, 1 signed, 2 carry-less |
| long_en | input | 1 | Widening mode |
| quad_en | input | 1 | Use 128-bit operands in same-width mode |
| src_a | input | VEC_W | First operand vector |
| src_b | input | VEC_W | Second operand vector |
| acc_in | input | VEC_W | Accumulator vector |
| out_valid | output | 1 | Result strobe |
| illegal | output | 1 | The last request was illegal |
| result | output | VEC_W | Registered result vector |

## Verification
The bench builds the unit with its default vector width of 128. At that width every mode is in reach: same-width 64-bit and 128-bit vectors, and widening from a 64-bit half into the full width. Random requests cover all lane sizes, operations and element kinds, including the encodings that must be rejected. Directed cases add lane overflow, sign-extended negative operands, the full carry-less product of 0xFF, and idle cycles in which the result must hold.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;
    typedef enum logic [1:0] {
        OP_MUL = 2'd0,
        OP_ADD = 2'd1,
        OP_SUB = 2'd2,
        OP_BAD = 2'd3
    } mac_op_e;

    typedef enum logic [1:0] {
        LN_8   = 2'd0,
        LN_16  = 2'd1,
        LN_32  = 2'd2,
        LN_BAD = 2'd3
    } lane_sz_e;

    typedef enum logic [1:0] {
        EK_UINT = 2'd0,
        EK_SINT = 2'd1,
        EK_POLY = 2'd2,
        EK_BAD  = 2'd3
    } elem_kind_e;

    localparam int unsigned NUM_SIZES = 3;
endpackage

// File: rtl/simd_mac_decode.sv
module simd_mac_decode
    import simd_mac_pkg::*;
(
    input  logic [1:0] op_i,
    input  logic [1:0] size_i,
    input  logic [1:0] kind_i,
    input  logic       long_i,
    input  logic       quad_i,
    output logic       bad_o
);
    mac_op_e    op;
    lane_sz_e   sz;
    elem_kind_e kind;

    always_comb begin
        op    = mac_op_e'(op_i);
        sz    = lane_sz_e'(size_i);
        kind  = elem_kind_e'(kind_i);
        bad_o = 1'b0;
        if (op == OP_BAD || sz == LN_BAD || kind == EK_BAD) bad_o = 1'b1;
        if (kind == EK_POLY && (op != OP_MUL || sz != LN_8)) bad_o = 1'b1;
        if (long_i && quad_i) bad_o = 1'b1;
    end
endmodule

// File: rtl/simd_mac_lanes.sv
module simd_mac_lanes #(
    parameter int unsigned VEC_W = 128,
    parameter int unsigned LW    = 8
) (
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    input  logic [VEC_W-1:0] acc_i,
    input  logic [1:0]       op_i,
    input  logic             signed_i,
    input  logic             poly_i,
    output logic [VEC_W-1:0] same_o,
    output logic [VEC_W-1:0] long_o
);
    localparam int unsigned LW2 = 2 * LW;
    localparam int unsigned NS  = VEC_W / LW;
    localparam int unsigned NL  = (VEC_W / 2) / LW;

    function automatic logic [LW2-1:0] clmul(input logic [LW-1:0] x, input logic [LW-1:0] y);
        logic [LW2-1:0] r;
        r = '0;
        for (int k = 0; k < LW; k++) begin
            if (y[k]) r = r ^ ({{LW{1'b0}}, x} << k);
        end
        return r;
    endfunction

    function automatic logic [LW-1:0] comb_n(input logic [1:0] op, input logic [LW-1:0] acc,
                                              input logic [LW-1:0] p);
        case (op)
            2'd1:    return acc + p;
            2'd2:    return acc - p;
            default: return p;
        endcase
    endfunction

    function automatic logic [LW2-1:0] comb_w(input logic [1:0] op, input logic [LW2-1:0] acc,
                                               input logic [LW2-1:0] p);
        case (op)
            2'd1:    return acc + p;
            2'd2:    return acc - p;
            default: return p;
        endcase
    endfunction

    for (genvar g = 0; g < NS; g++) begin : g_same
        logic [LW-1:0]  xa, xb, xc;
        logic [LW2-1:0] full;
        assign xa   = a_i[g*LW +: LW];
        assign xb   = b_i[g*LW +: LW];
        assign xc   = acc_i[g*LW +: LW];
        assign full = poly_i ? clmul(xa, xb) : LW2'(xa) * LW2'(xb);
        assign same_o[g*LW +: LW] = comb_n(op_i, xc, full[LW-1:0]);
    end

    for (genvar g = 0; g < NL; g++) begin : g_long
        logic [LW-1:0]  xa, xb;
        logic [LW2-1:0] ea, eb, xc, prod;
        assign xa   = a_i[g*LW +: LW];
        assign xb   = b_i[g*LW +: LW];
        assign ea   = {{LW{signed_i & xa[LW-1]}}, xa};
        assign eb   = {{LW{signed_i & xb[LW-1]}}, xb};
        assign xc   = acc_i[g*LW2 +: LW2];
        assign prod = poly_i ? clmul(xa, xb) : ea * eb;
        assign long_o[g*LW2 +: LW2] = comb_w(op_i, xc, prod);
    end
endmodule

// File: rtl/simd_mac_unit.sv
module simd_mac_unit
    import simd_mac_pkg::*;
#(
    parameter int unsigned VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       op_sel,
    input  logic [1:0]       lane_sel,
    input  logic [1:0]       elem_kind,
    input  logic             long_en,
    input  logic             quad_en,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [VEC_W-1:0] acc_in,
    output logic             out_valid,
    output logic             illegal,
    output logic [VEC_W-1:0] result
);
    localparam int unsigned HALF_W = VEC_W / 2;

    typedef struct packed {
        logic             vld;
        logic             bad;
        logic [VEC_W-1:0] res;
    } mac_state_t;

    mac_state_t state_d, state_q;
    logic       bad_d;
    logic [VEC_W-1:0] same_r [NUM_SIZES];
    logic [VEC_W-1:0] long_r [NUM_SIZES];
    logic [VEC_W-1:0] pick_same, pick_long, fresh;

    simd_mac_decode dec_i (
        .op_i   (op_sel),
        .size_i (lane_sel),
        .kind_i (elem_kind),
        .long_i (long_en),
        .quad_i (quad_en),
        .bad_o  (bad_d)
    );

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        simd_mac_lanes #(
            .VEC_W (VEC_W),
            .LW    (8 << s)
        ) lanes_i (
            .a_i      (src_a),
            .b_i      (src_b),
            .acc_i    (acc_in),
            .op_i     (op_sel),
            .signed_i (elem_kind == EK_SINT),
            .poly_i   (elem_kind == EK_POLY),
            .same_o   (same_r[s]),
            .long_o   (long_r[s])
        );
    end

    always_comb begin
        case (lane_sz_e'(lane_sel))
            LN_16:   begin pick_same = same_r[1]; pick_long = long_r[1]; end
            LN_32:   begin pick_same = same_r[2]; pick_long = long_r[2]; end
            default: begin pick_same = same_r[0]; pick_long = long_r[0]; end
        endcase

        if (long_en)      fresh = pick_long;
        else if (quad_en) fresh = pick_same;
        else              fresh = {{HALF_W{1'b0}}, pick_same[HALF_W-1:0]};

        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.bad = bad_d;
            if (!bad_d) state_d.res = fresh;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign out_valid = state_q.vld;
    assign illegal   = state_q.bad;
    assign result    = state_q.res;
endmodule

// File: rtl/simd_mac_chk.sv
module simd_mac_chk #(
    parameter int unsigned VEC_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       op_sel,
    input logic [1:0]       lane_sel,
    input logic [1:0]       elem_kind,
    input logic             long_en,
    input logic             quad_en,
    input logic             out_valid,
    input logic             illegal,
    input logic [VEC_W-1:0] result
);
    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result) && $stable(illegal)));

    // R8
    poly_accum_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && elem_kind == 2'd2 && op_sel != 2'd0) |=> illegal);

    // R8
    long_quad_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && long_en && quad_en) |=> (illegal && $stable(result)));

    // R5
    half_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !long_en && !quad_en && op_sel != 2'd3 && lane_sel != 2'd3
         && elem_kind < 2'd2) |=> (result[VEC_W-1:VEC_W/2] == '0));
endmodule

bind simd_mac_unit simd_mac_chk #(.VEC_W(VEC_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .lane_sel  (lane_sel),
    .elem_kind (elem_kind),
    .long_en   (long_en),
    .quad_en   (quad_en),
    .out_valid (out_valid),
    .illegal   (illegal),
    .result    (result)
);

// File: tb/simd_mac_unit_tb.sv
module simd_mac_unit_tb_top;
    localparam int unsigned VW = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    op_sel = '0, lane_sel = '0, elem_kind = '0;
    logic          long_en = 1'b0, quad_en = 1'b0;
    logic [VW-1:0] src_a = '0, src_b = '0, acc_in = '0;
    logic          out_valid, illegal;
    logic [VW-1:0] result;

    int unsigned n_run = 0, n_fail = 0;
    logic        done = 1'b0;
    logic [VW-1:0] prev_res = '0;
    logic          prev_bad = 1'b0;

    always #10 clk = ~clk;

    simd_mac_unit #(.VEC_W(VW)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .lane_sel(lane_sel), .elem_kind(elem_kind), .long_en(long_en),
        .quad_en(quad_en), .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
        .out_valid(out_valid), .illegal(illegal), .result(result)
    );

    function automatic logic [63:0] gf_mul(input logic [63:0] x, input logic [63:0] y, input int lw);
        logic [63:0] r = '0;
        for (int k = 0; k < lw; k++) if (y[k]) r = r ^ (x << k);
        return r;
    endfunction

    function automatic logic is_bad(input logic [1:0] op, input logic [1:0] sz, input logic [1:0] kd,
                                    input logic lg, input logic qd);
        return op == 3 || sz == 3 || kd == 3 || (kd == 2 && (op != 0 || sz != 0)) || (lg && qd);
    endfunction

    function automatic logic [VW-1:0] model(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                            input logic [VW-1:0] c, input logic [1:0] op,
                                            input logic [1:0] sz, input logic [1:0] kd,
                                            input logic lg, input logic qd);
        logic [VW-1:0] r = '0;
        int lw = 8 << sz;
        int ow = lg ? 2 * lw : lw;
        int n  = lg ? 64 / lw : (qd ? 128 : 64) / lw;
        logic [63:0] m  = (64'd1 << lw) - 1;
        logic [63:0] mo = (ow == 64) ? '1 : ((64'd1 << ow) - 1);
        for (int i = 0; i < n; i++) begin
            logic [63:0] x, y, z, p, v;
            x = 64'(a >> (i * lw)) & m;
            y = 64'(b >> (i * lw)) & m;
            z = 64'(c >> (i * ow)) & mo;
            if (lg && kd == 1) begin
                if (x[lw-1]) x = x | ~m;
                if (y[lw-1]) y = y | ~m;
            end
            p = (kd == 2) ? gf_mul(x, y, lw) : x * y;
            p = p & mo;
            case (op)
                2'd1:    v = (z + p) & mo;
                2'd2:    v = (z - p) & mo;
                default: v = p;
            endcase
            r = r | (VW'(v) << (i * ow));
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    task automatic issue(input string req, input logic [VW-1:0] a, input logic [VW-1:0] b,
                         input logic [VW-1:0] c, input logic [1:0] op, input logic [1:0] sz,
                         input logic [1:0] kd, input logic lg, input logic qd);
        logic bad;
        logic [VW-1:0] exp;
        src_a = a; src_b = b; acc_in = c; op_sel = op; lane_sel = sz;
        elem_kind = kd; long_en = lg; quad_en = qd; in_valid = 1'b1;
        bad = is_bad(op, sz, kd, lg, qd);
        exp = bad ? prev_res : model(a, b, c, op, sz, kd, lg, qd);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R9 valid"}, VW'(out_valid), VW'(1));
        check({req, " R8 flag"}, VW'(illegal), VW'(bad));
        check({req, " result"}, result, exp);
        prev_res = exp;
        prev_bad = bad;
    endtask

    function automatic logic [VW-1:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        void'($urandom(32'h5EED_0A1B));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check("R9 reset valid", VW'(out_valid), '0);
        check("R9 reset illegal", VW'(illegal), '0);
        check("R9 reset result", result, '0);

        // R1 R4 R10: 8-bit lanes, overflow stays in lane
        issue("R1 R10 mul8", {16{8'hFF}}, {16{8'h03}}, '0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1);
        // R2 wraps modulo lane
        issue("R2 add16", {8{16'hFFFF}}, {8{16'h0001}}, {8{16'h0002}}, 2'd1, 2'd1, 2'd0, 1'b0, 1'b1);
        // R3 wraps below zero
        issue("R3 sub32", {4{32'h0000_0002}}, {4{32'h0000_0003}}, {4{32'h0000_0001}}, 2'd2, 2'd2, 2'd0, 1'b0, 1'b1);
        // R5 64-bit mode ignores upper half
        issue("R5 half", rnd128(), rnd128(), rnd128(), 2'd1, 2'd0, 2'd0, 1'b0, 1'b0);
        // R6 signed widening of negatives
        issue("R6 long signed", {2{32'hFFFF_FFFF}}, {2{32'hFFFF_FFFE}}, '0, 2'd0, 2'd2, 2'd1, 1'b1, 1'b0);
        issue("R6 long unsigned", {8{8'hFF}}, {8{8'hFF}}, {8{16'h0001}}, 2'd1, 2'd0, 2'd0, 1'b1, 1'b0);
        // R7 carry-less products
        issue("R7 poly", {16{8'hFF}}, {16{8'hFF}}, '0, 2'd0, 2'd0, 2'd2, 1'b0, 1'b1);
        issue("R7 poly long", {8{8'hFF}}, {8{8'hFF}}, '0, 2'd0, 2'd0, 2'd2, 1'b1, 1'b0);
        // R8 illegal combinations keep the result
        issue("R8 poly add", rnd128(), rnd128(), rnd128(), 2'd1, 2'd0, 2'd2, 1'b0, 1'b1);
        issue("R8 long quad", rnd128(), rnd128(), rnd128(), 2'd0, 2'd1, 2'd0, 1'b1, 1'b1);

        // R11 idle cycles hold
        @(negedge clk);
        check("R11 idle valid", VW'(out_valid), '0);
        check("R11 idle result", result, prev_res);
        check("R11 idle illegal", VW'(illegal), VW'(prev_bad));

        for (int t = 0; t < 600; t++) begin
            logic [1:0] op, sz, kd;
            logic lg, qd;
            op = 2'($urandom_range(0, 3));
            sz = 2'($urandom_range(0, 3));
            kd = 2'($urandom_range(0, 3));
            lg = 1'($urandom_range(0, 1));
            qd = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 3) != 0) begin
                if (op == 3) op = 0;
                if (sz == 3) sz = 2;
                if (kd == 3) kd = 1;
                if (kd == 2) begin op = 0; sz = 0; end
                if (lg) qd = 0;
            end
            issue("R1 R2 R3 R4 R6 random", rnd128(), rnd128(), rnd128(), op, sz, kd, lg, qd);
            if ($urandom_range(0, 7) == 0) begin
                @(negedge clk);
                check("R11 random idle", result, prev_res);
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule